// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block lets a simple in-order processor repeat a run of instructions without a branch instruction at the end of the body. A setup strobe loads three values: the address of the first instruction of the body (loop top), the address that marks the end of the body (loop end), and the number of passes still to run. From then on, each retired instruction presents its next program counter. When that value equals the stored loop end while a loop is running, the block either sends fetch back to loop top or, on the last pass, lets the next PC through unchanged and ends the loop.

The redirect is combinational. `pc_o` is the address the fetch stage should use in the same cycle. The stored state (the pass counter and the running flag) changes on the following clock edge. Addresses are 16-bit instruction-word addresses. Only one loop level is held, so a new setup replaces whatever loop is running.

A two-state machine holds the control. `LP_IDLE` means no loop is running and `LP_RUN` means a loop is running. Its transitions are:
- load: `LP_IDLE` to `LP_RUN`, on a setup with a nonzero count.
- reload: `LP_RUN` to `LP_RUN`, on a setup with a nonzero count.
- cancel: `LP_RUN` to `LP_IDLE`, on a setup with a zero count.
- finish: `LP_RUN` to `LP_IDLE`, on a hit with one pass left.
- iterate: `LP_RUN` to `LP_RUN`, on a hit with more than one pass left.
- stay: `LP_IDLE` to `LP_IDLE`, in every other case while idle.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset, `active_o` is 0, `count_o` is 0, and loop top and loop end are cleared, so `pc_o` equals `next_pc_i`.
- R2: A setup strobe with a nonzero count makes `active_o` 1 and `count_o` equal to the loaded count on the next cycle.
- R3: When no hit occurs, `pc_o` equals `next_pc_i` in the same cycle and the loop state does not change. A hit is a retire while active with `next_pc_i` equal to loop end.
- R4: On a hit with `count_o` greater than 1, `pc_o` equals loop top in the same cycle, and `count_o` is one lower on the next cycle while `active_o` stays 1.
- R5: On a hit with `count_o` equal to 1, `pc_o` equals `next_pc_i` (fall-through), and on the next cycle `active_o` is 0 and `count_o` is 0.
- R6: A setup strobe with a count of zero leaves `active_o` at 0 on the next cycle, so a later retire at the loop-end address is not redirected.
- R7: A setup strobe always overwrites top, end and count, even while a loop runs. When setup and a hit occur in the same cycle, `pc_o` follows the old loop state and the new setup values are what is stored.
- R8: Whenever `active_o` is 1, `count_o` is nonzero.
- R9: Without a retire strobe, a `next_pc_i` equal to loop end neither redirects nor changes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| setup_i | input | 1 | Loop setup strobe |
| setup_top_i | input | 16 | Loop top address to load |
| setup_end_i | input | 16 | Loop end address to load |
| setup_count_i | input | 16 | Number of passes to load |
| retire_i | input | 1 | Instruction retire strobe |
| next_pc_i | input | 16 | Next PC of the retiring instruction |
| pc_o | output | 16 | PC for fetch, after any redirect |
| active_o | output | 1 | A loop is running |
| count_o | output | 16 | Passes remaining |

## Verification
`pc_o` is due in the same cycle as the inputs that cause it, so the bench drives inputs on the falling edge and compares `pc_o` one nanosecond later, before the next rising edge. `active_o` and `count_o` are due one rising edge after a setup or a hit. The bench updates its own model at that rising edge and compares the state outputs at the following falling edge. A mix of directed passes and seeded random traffic biases `next_pc_i` toward the loop-end address to exercise hits often.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
    typedef enum logic [0:0] {
        LP_IDLE = 1'b0,
        LP_RUN  = 1'b1
    } lp_state_e;
endpackage

// File: rtl/hwloop_match.sv
module hwloop_match #(
    parameter int AW = 16
) (
    input  logic          active_i,
    input  logic          retire_i,
    input  logic          last_i,
    input  logic [AW-1:0] next_pc_i,
    input  logic [AW-1:0] end_i,
    input  logic [AW-1:0] top_i,
    output logic          hit_o,
    output logic [AW-1:0] pc_o
);
    always_comb begin
        hit_o = active_i && retire_i && (next_pc_i == end_i);
        pc_o  = (hit_o && !last_i) ? top_i : next_pc_i;
    end
endmodule

// File: rtl/hwloop_fsm.sv
module hwloop_fsm
    import hwloop_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          setup_i,
    input  logic [AW-1:0] setup_top_i,
    input  logic [AW-1:0] setup_end_i,
    input  logic [CW-1:0] setup_count_i,
    input  logic          hit_i,
    output logic [AW-1:0] top_q,
    output logic [AW-1:0] end_q,
    output logic [CW-1:0] count_q,
    output logic          active_o,
    output logic          last_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    lp_state_e state_q, state_d;
    logic      setup_nz;

    assign setup_nz = (setup_count_i != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LP_IDLE: if (setup_i && setup_nz) state_d = LP_RUN;
            LP_RUN: begin
                if (setup_i)                     state_d = setup_nz ? LP_RUN : LP_IDLE;
                else if (hit_i && count_q == ONE) state_d = LP_IDLE;
            end
            default: state_d = LP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q   <= '0;
            end_q   <= '0;
            count_q <= '0;
        end else if (setup_i) begin
            top_q   <= setup_top_i;
            end_q   <= setup_end_i;
            count_q <= setup_count_i;
        end else if (hit_i) begin
            count_q <= count_q - ONE;
        end
    end

    always_comb begin
        active_o = (state_q == LP_RUN);
        last_o   = (count_q == ONE);
    end
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          setup_i,
    input  logic [AW-1:0] setup_top_i,
    input  logic [AW-1:0] setup_end_i,
    input  logic [CW-1:0] setup_count_i,
    input  logic          retire_i,
    input  logic [AW-1:0] next_pc_i,
    output logic [AW-1:0] pc_o,
    output logic          active_o,
    output logic [CW-1:0] count_o
);
    logic [AW-1:0] top_q, end_q;
    logic          hit, last;

    hwloop_fsm #(.AW(AW), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .setup_i(setup_i), .setup_top_i(setup_top_i),
        .setup_end_i(setup_end_i), .setup_count_i(setup_count_i),
        .hit_i(hit), .top_q(top_q), .end_q(end_q),
        .count_q(count_o), .active_o(active_o), .last_o(last)
    );

    hwloop_match #(.AW(AW)) u_match (
        .active_i(active_o), .retire_i(retire_i), .last_i(last),
        .next_pc_i(next_pc_i), .end_i(end_q), .top_i(top_q),
        .hit_o(hit), .pc_o(pc_o)
    );
endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          setup_i,
    input logic [CW-1:0] setup_count_i,
    input logic          retire_i,
    input logic [AW-1:0] next_pc_i,
    input logic [AW-1:0] pc_o,
    input logic          active_o,
    input logic [CW-1:0] count_o,
    input logic [AW-1:0] top_q,
    input logic [AW-1:0] end_q
);
    logic hit_c;
    assign hit_c = active_o && retire_i && (next_pc_i == end_q);

    p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_c |-> pc_o == next_pc_i);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!setup_i && !hit_c) |=> $stable(count_o));
    p_redirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_c && count_o > CW'(1)) |-> pc_o == top_q);
    p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_c && !setup_i) |=> count_o == $past(count_o) - CW'(1));
    p_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_c && !setup_i && count_o == CW'(1)) |=> !active_o);
    p_zero_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_i && setup_count_i == '0) |=> !active_o);
    p_overwrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        setup_i |=> count_o == $past(setup_count_i));
    p_count_nz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> count_o != '0);
    p_no_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire_i && !setup_i) |=> $stable(count_o) && $stable(active_o));
endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .setup_i(setup_i), .setup_count_i(setup_count_i),
    .retire_i(retire_i), .next_pc_i(next_pc_i), .pc_o(pc_o),
    .active_o(active_o), .count_o(count_o), .top_q(top_q), .end_q(end_q)
);

// File: tb/hwloop_ctrl_tb.sv
`timescale 1ns/1ps
module hwloop_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        setup_i = 1'b0;
    logic [15:0] setup_top_i = '0, setup_end_i = '0, setup_count_i = '0;
    logic        retire_i = 1'b0;
    logic [15:0] next_pc_i = '0;
    logic [15:0] pc_o, count_o;
    logic        active_o;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    logic        m_active = 0;
    logic [15:0] m_top = 0, m_end = 0, m_count = 0;

    always #4 clk = ~clk;

    hwloop_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .setup_i(setup_i), .setup_top_i(setup_top_i),
        .setup_end_i(setup_end_i), .setup_count_i(setup_count_i),
        .retire_i(retire_i), .next_pc_i(next_pc_i),
        .pc_o(pc_o), .active_o(active_o), .count_o(count_o)
    );

    function automatic logic m_hit(logic ret, logic [15:0] npc);
        return m_active && ret && (npc == m_end);
    endfunction

    function automatic logic [15:0] exp_pc(logic ret, logic [15:0] npc);
        return (m_hit(ret, npc) && m_count != 16'd1) ? m_top : npc;
    endfunction

    task automatic chk(string tag, logic ok, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cycle(logic su, logic [15:0] top, logic [15:0] en, logic [15:0] cnt,
                         logic ret, logic [15:0] npc);
        string tag;
        logic [15:0] e;
        @(negedge clk);
        setup_i = su; setup_top_i = top; setup_end_i = en; setup_count_i = cnt;
        retire_i = ret; next_pc_i = npc;
        #1;
        chk("R2 active", active_o == m_active, active_o, m_active);
        chk("R2 count", count_o == m_count, count_o, m_count);
        if (m_active) chk("R8 count nonzero", count_o != 0, count_o, 1);
        if (!ret) tag = "R9";
        else if (m_hit(ret, npc) && m_count == 16'd1) tag = "R5";
        else if (m_hit(ret, npc)) tag = "R4";
        else tag = "R3";
        e = exp_pc(ret, npc);
        chk({tag, " pc"}, pc_o == e, pc_o, e);
        @(posedge clk);
        if (su) begin
            m_top = top; m_end = en; m_count = cnt; m_active = (cnt != 0);
        end else if (m_hit(ret, npc)) begin
            m_count = m_count - 1;
            if (m_count == 0) m_active = 0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1f2e3d4c));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 active", active_o == 0, active_o, 0);
        chk("R1 count", count_o == 0, count_o, 0);
        next_pc_i = 16'h0000; retire_i = 1; #1;
        chk("R1 pc passthrough", pc_o == 16'h0000, pc_o, 0);
        retire_i = 0;
        @(negedge clk); rst_n = 1;

        // R2/R4/R5: three passes over body 5..9
        cycle(1, 16'd5, 16'd9, 16'd3, 0, 16'd0);
        cycle(0, 0, 0, 0, 1, 16'd6);
        cycle(0, 0, 0, 0, 1, 16'd9);
        cycle(0, 0, 0, 0, 0, 16'd9);   // R9 no retire
        cycle(0, 0, 0, 0, 1, 16'd9);
        cycle(0, 0, 0, 0, 1, 16'd9);   // R5 fall through
        cycle(0, 0, 0, 0, 1, 16'd9);   // R3 idle now
        chk("R5 inactive", active_o == 0, active_o, 0);

        // R6 zero-count setup
        cycle(1, 16'd20, 16'd30, 16'd0, 0, 16'd0);
        cycle(0, 0, 0, 0, 1, 16'd30);
        chk("R6 inactive", active_o == 0, active_o, 0);

        // R7 overwrite while active, and setup with simultaneous hit
        cycle(1, 16'd100, 16'd110, 16'd4, 0, 16'd0);
        cycle(1, 16'd200, 16'd210, 16'd2, 1, 16'd110);
        cycle(0, 0, 0, 0, 1, 16'd110);
        chk("R7 new end only", count_o == 16'd2, count_o, 2);
        cycle(0, 0, 0, 0, 1, 16'd210);
        cycle(0, 0, 0, 0, 1, 16'd210);
        // R7 cancel by zero-count setup while running
        cycle(1, 16'd1, 16'd2, 16'd5, 0, 16'd0);
        cycle(1, 16'd1, 16'd2, 16'd0, 1, 16'd2);
        cycle(0, 0, 0, 0, 1, 16'd2);
        chk("R7 cancelled", active_o == 0, active_o, 0);

        // random traffic
        for (int i = 0; i < 2000; i++) begin
            logic su, ret;
            logic [15:0] t, en, c, npc;
            su  = ($urandom_range(0, 15) == 0);
            t   = 16'($urandom_range(0, 63));
            en  = 16'($urandom_range(0, 63));
            c   = 16'($urandom_range(0, 4));
            ret = ($urandom_range(0, 3) != 0);
            npc = ($urandom_range(0, 1) == 0) ? m_end : 16'($urandom_range(0, 63));
            cycle(su, t, en, c, ret, npc);
        end
        @(negedge clk);
        finish_run();
    end
endmodule